// File: doc/BRIEF.md
# Flash Address Width and Extended Address Byte Logic

This block holds the address-width state of a serial NOR flash slave. Commands reach it already deserialized: a one-cycle opcode strobe with the opcode byte, then one-cycle data strobes that each carry a byte. The block keeps a width flag that selects 3-byte or 4-byte addressing. It also keeps an 8-bit extended address byte, which supplies bits 31..24 of the array address whenever the block runs in 3-byte mode.

For each address-carrying command the block gathers the address bytes, most significant first. One cycle after the last of them it issues a valid pulse with the effective 32-bit address. The extended byte also changes as a side effect of normal traffic. Every command with a full 4-byte address copies its top byte into it. Leaving 4-byte mode sets it to 1, not to 0. Host software must therefore rewrite it before it relies on 3-byte accesses. The width flag and the extended byte are visible on ports, and a read-back command returns the extended byte through a separate strobe.

Top module: `flash_addr_xlate`

## Requirements
- R1: Synchronous reset leaves the width flag at 0 (3-byte mode), the extended byte at 0x00, and both valid outputs low.
- R2: Opcode 0xB7 sets the width flag. Opcode 0xE9 clears it. When 0xE9 arrives while the flag is 1, the extended byte becomes 0x01. When it arrives while the flag is already 0, the extended byte is left unchanged.
- R3: Opcode 0xC5 followed by one data byte stores that byte in the extended byte, visible the cycle after the data strobe.
- R4: Opcode 0xC8 produces a one-cycle read-back strobe in the cycle after the opcode, carrying the current extended byte.
- R5: The width-following opcodes 0x03, 0x02, 0x0B, 0x20 and 0xD8 take 3 address bytes while the flag is 0. The effective address is {extended byte, byte1, byte2, byte3}, and the address valid pulse comes one cycle after the third byte.
- R6: While the flag is 1, the width-following opcodes take 4 address bytes and the address is {byte1..byte4}. The extended byte plays no part in it. Byte1 is copied into the extended byte on the same edge that raises the valid pulse.
- R7: The fixed-width opcodes 0x13, 0x12, 0x0C, 0x21 and 0xDC always take 4 address bytes, whatever the flag holds. They give {byte1..byte4} and copy byte1 into the extended byte.
- R8: Unrecognized opcodes, and data bytes that arrive when no address or extended-byte write is pending, change neither output nor state.
- R9: An opcode strobe abandons any partly gathered address. A data strobe in the same cycle as an opcode strobe is ignored.
- R10: The sequence 0xE9, then 0xC5 with 0x00, then a 3-byte read of address 0 yields effective address 0x00000000.
- R11: The address valid pulse lasts exactly one cycle per completed address command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Opcode strobe |
| cmd_op | input | 8 | Opcode byte |
| dat_stb | input | 1 | Data/address byte strobe |
| dat_byte | input | 8 | Data/address byte |
| addr_vld | output | 1 | Effective address valid pulse |
| addr_eff | output | 32 | Effective array address |
| wide_mode | output | 1 | Width flag, 1 = 4-byte addressing |
| ext_byte | output | 8 | Current extended address byte |
| ext_rd_vld | output | 1 | Read-back strobe for opcode 0xC8 |
| ext_rd_byte | output | 8 | Read-back value |

## Verification
The assertions check the single-cycle behaviour on every cycle. They cover the mode-exit load of 0x01, the mode-entry set, the data-byte and top-byte writes into the extended byte, the one-cycle width of the valid pulse, the absence of a valid pulse right after an opcode, and read-back consistency. Other behaviour can only be shown by the bench's command sequences. That includes how the extended byte is composed into 3-byte addresses, the byte count chosen by mode and opcode, abandoned commands, ignored traffic, and the exit-then-rewrite recovery sequence. The bench also mixes random commands against a reference model.

// File: rtl/flash_addr_pkg.sv
package flash_addr_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_BYTES = 4;
    localparam int unsigned ADDR_W     = BYTE_W * ADDR_BYTES;
    localparam int unsigned SH_W       = ADDR_W - BYTE_W;
    localparam int unsigned LOW_W      = SH_W - BYTE_W;
    localparam int unsigned CNT_W      = $clog2(ADDR_BYTES + 1);

    localparam logic [BYTE_W-1:0] OP_ENTER_WIDE = 8'hB7;
    localparam logic [BYTE_W-1:0] OP_EXIT_WIDE  = 8'hE9;
    localparam logic [BYTE_W-1:0] OP_EXT_WRITE  = 8'hC5;
    localparam logic [BYTE_W-1:0] OP_EXT_READ   = 8'hC8;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_FOLLOW,
        CK_FIXED4,
        CK_ENTER,
        CK_EXIT,
        CK_WREXT,
        CK_RDEXT
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_EXTDATA
    } seq_state_e;

    typedef struct packed {
        logic              enter;
        logic              leave;
        logic              wr;
        logic              load_top;
        logic [BYTE_W-1:0] data;
    } ext_req_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } addr_beat_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rd_beat_t;

    function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] op);
        cmd_kind_e k;
        case (op)
            8'h03, 8'h02, 8'h0B, 8'h20, 8'hD8: k = CK_FOLLOW;
            8'h13, 8'h12, 8'h0C, 8'h21, 8'hDC: k = CK_FIXED4;
            OP_ENTER_WIDE:                     k = CK_ENTER;
            OP_EXIT_WIDE:                      k = CK_EXIT;
            OP_EXT_WRITE:                      k = CK_WREXT;
            OP_EXT_READ:                       k = CK_RDEXT;
            default:                           k = CK_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [CNT_W-1:0] bytes_needed(input cmd_kind_e k,
                                                      input logic wide);
        logic [CNT_W-1:0] n;
        if (k == CK_FIXED4 || wide) n = CNT_W'(ADDR_BYTES);
        else                        n = CNT_W'(ADDR_BYTES - 1);
        return n;
    endfunction

endpackage

// File: rtl/fa_mode_ext.sv
module fa_mode_ext
    import flash_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ext_req_t          req,
    output logic              mode_o,
    output logic [BYTE_W-1:0] ext_o
);

    logic              mode_q;
    logic [BYTE_W-1:0] ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            ext_q  <= '0;
        end else begin
            if (req.enter) mode_q <= 1'b1;
            if (req.leave) begin
                mode_q <= 1'b0;
                if (mode_q) ext_q <= BYTE_W'(1);
            end
            if (req.wr || req.load_top) ext_q <= req.data;
        end
    end

    assign mode_o = mode_q;
    assign ext_o  = ext_q;

    a_r2_exit_loads_one: assert property (@(posedge clk) disable iff (rst)
        (req.leave && mode_q) |=> (!mode_q && ext_q == BYTE_W'(1)));

    a_r2_enter_sets_flag: assert property (@(posedge clk) disable iff (rst)
        req.enter |=> mode_q);

    a_r3_data_write: assert property (@(posedge clk) disable iff (rst)
        req.wr |=> (ext_q == $past(req.data)));

    a_r7_top_byte_copy: assert property (@(posedge clk) disable iff (rst)
        req.load_top |=> (ext_q == $past(req.data)));

endmodule

// File: rtl/fa_cmd_seq.sv
module fa_cmd_seq
    import flash_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [BYTE_W-1:0] op_code,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              mode_i,
    input  logic [BYTE_W-1:0] ext_i,
    output ext_req_t          req_o,
    output addr_beat_t        addr_o,
    output rd_beat_t          rd_o
);

    seq_state_e        st_q;
    logic [CNT_W-1:0]  need_q;
    logic [CNT_W-1:0]  got_q;
    logic              wide_q;
    logic [SH_W-1:0]   sh_q;
    addr_beat_t        addr_q;
    rd_beat_t          rd_q;

    cmd_kind_e         kind;
    logic              take_byte;
    logic              last_byte;
    logic [ADDR_W-1:0] final_addr;

    always_comb begin
        kind       = classify(op_code);
        take_byte  = byte_valid && !op_valid;
        last_byte  = (st_q == SQ_ADDR) && take_byte &&
                     ((got_q + CNT_W'(1)) == need_q);
        if (wide_q) final_addr = {sh_q, byte_data};
        else        final_addr = {ext_i, sh_q[LOW_W-1:0], byte_data};

        req_o.enter    = op_valid && (kind == CK_ENTER);
        req_o.leave    = op_valid && (kind == CK_EXIT);
        req_o.wr       = (st_q == SQ_EXTDATA) && take_byte;
        req_o.load_top = last_byte && wide_q;
        req_o.data     = req_o.wr ? byte_data : sh_q[SH_W-1 -: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            need_q <= '0;
            got_q  <= '0;
            wide_q <= 1'b0;
            sh_q   <= '0;
            addr_q <= '0;
            rd_q   <= '0;
        end else begin
            addr_q.valid <= 1'b0;
            rd_q.valid   <= 1'b0;
            if (op_valid) begin
                got_q <= '0;
                case (kind)
                    CK_FOLLOW, CK_FIXED4: begin
                        st_q   <= SQ_ADDR;
                        need_q <= bytes_needed(kind, mode_i);
                        wide_q <= (kind == CK_FIXED4) || mode_i;
                    end
                    CK_WREXT: st_q <= SQ_EXTDATA;
                    CK_RDEXT: begin
                        st_q       <= SQ_IDLE;
                        rd_q.valid <= 1'b1;
                        rd_q.data  <= ext_i;
                    end
                    default: st_q <= SQ_IDLE;
                endcase
            end else if (take_byte) begin
                case (st_q)
                    SQ_ADDR: begin
                        sh_q  <= {sh_q[SH_W-BYTE_W-1:0], byte_data};
                        got_q <= got_q + CNT_W'(1);
                        if (last_byte) begin
                            st_q         <= SQ_IDLE;
                            addr_q.valid <= 1'b1;
                            addr_q.addr  <= final_addr;
                        end
                    end
                    SQ_EXTDATA: st_q <= SQ_IDLE;
                    default:    st_q <= SQ_IDLE;
                endcase
            end
        end
    end

    assign addr_o = addr_q;
    assign rd_o   = rd_q;

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        addr_q.valid |=> !addr_q.valid);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_IDLE && !op_valid) |=> !addr_q.valid);

    a_r9_opcode_restarts: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !addr_q.valid);

endmodule

// File: rtl/flash_addr_xlate.sv
module flash_addr_xlate
    import flash_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  logic [BYTE_W-1:0] cmd_op,
    input  logic              dat_stb,
    input  logic [BYTE_W-1:0] dat_byte,
    output logic              addr_vld,
    output logic [ADDR_W-1:0] addr_eff,
    output logic              wide_mode,
    output logic [BYTE_W-1:0] ext_byte,
    output logic              ext_rd_vld,
    output logic [BYTE_W-1:0] ext_rd_byte
);

    ext_req_t          req;
    addr_beat_t        beat;
    rd_beat_t          rd;
    logic              mode_w;
    logic [BYTE_W-1:0] ext_w;

    fa_cmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (cmd_stb),
        .op_code    (cmd_op),
        .byte_valid (dat_stb),
        .byte_data  (dat_byte),
        .mode_i     (mode_w),
        .ext_i      (ext_w),
        .req_o      (req),
        .addr_o     (beat),
        .rd_o       (rd)
    );

    fa_mode_ext u_mode (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .mode_o (mode_w),
        .ext_o  (ext_w)
    );

    assign addr_vld    = beat.valid;
    assign addr_eff    = beat.addr;
    assign wide_mode   = mode_w;
    assign ext_byte    = ext_w;
    assign ext_rd_vld  = rd.valid;
    assign ext_rd_byte = rd.data;

    a_r4_readback_matches: assert property (@(posedge clk) disable iff (rst)
        ext_rd_vld |-> (ext_rd_byte == ext_byte));

endmodule

// File: tb/tb_flash_addr_xlate.sv
module tb_flash_addr_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_stb = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic        dat_stb = 1'b0;
    logic [7:0]  dat_byte = '0;
    logic        addr_vld;
    logic [31:0] addr_eff;
    logic        wide_mode;
    logic [7:0]  ext_byte;
    logic        ext_rd_vld;
    logic [7:0]  ext_rd_byte;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic        m_mode = 1'b0;
    logic [7:0]  m_ext = 8'h00;

    always #5 clk = ~clk;

    flash_addr_xlate dut (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
        .dat_stb(dat_stb), .dat_byte(dat_byte), .addr_vld(addr_vld),
        .addr_eff(addr_eff), .wide_mode(wide_mode), .ext_byte(ext_byte),
        .ext_rd_vld(ext_rd_vld), .ext_rd_byte(ext_rd_byte)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic bit fixed4(input logic [7:0] op);
        return op == 8'h13 || op == 8'h12 || op == 8'h0C || op == 8'h21 || op == 8'hDC;
    endfunction

    function automatic logic [31:0] model_addr(input bit wide, input logic [31:0] b,
                                               input logic [7:0] ext);
        return wide ? b : {ext, b[23:0]};
    endfunction

    task automatic send_op(input logic [7:0] op, input bit with_byte = 1'b0);
        cmd_stb = 1'b1; cmd_op = op;
        dat_stb = with_byte; dat_byte = 8'hEE;
        @(negedge clk);
        cmd_stb = 1'b0; dat_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        dat_stb = 1'b1; dat_byte = b;
        @(negedge clk);
        dat_stb = 1'b0;
    endtask

    task automatic do_mode(input logic [7:0] op);
        send_op(op);
        if (op == 8'hB7) m_mode = 1'b1;
        else begin
            if (m_mode) m_ext = 8'h01;
            m_mode = 1'b0;
        end
        chk("R2 flag", {31'd0, wide_mode}, {31'd0, m_mode});
        chk("R2 ext", {24'd0, ext_byte}, {24'd0, m_ext});
    endtask

    task automatic do_wrext(input logic [7:0] v);
        send_op(8'hC5);
        send_byte(v);
        m_ext = v;
        chk("R3 ext write", {24'd0, ext_byte}, {24'd0, m_ext});
    endtask

    task automatic do_rdext();
        send_op(8'hC8);
        chk("R4 rd strobe", {31'd0, ext_rd_vld}, 32'd1);
        chk("R4 rd data", {24'd0, ext_rd_byte}, {24'd0, m_ext});
        @(negedge clk);
        chk("R4 rd one cycle", {31'd0, ext_rd_vld}, 32'd0);
    endtask

    task automatic do_addr(input string req, input logic [7:0] op,
                           input logic [31:0] b, input bit gaps);
        bit wide;
        int n;
        logic [31:0] exp;
        wide = fixed4(op) || m_mode;
        n = wide ? 4 : 3;
        send_op(op);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                @(negedge clk);
                chk({req, " gap quiet"}, {31'd0, addr_vld}, 32'd0);
            end
            send_byte(wide ? b[31-8*i -: 8] : b[23-8*i -: 8]);
            if (i < n - 1)
                chk({req, " early quiet"}, {31'd0, addr_vld}, 32'd0);
        end
        exp = model_addr(wide, b, m_ext);
        if (wide) m_ext = b[31:24];
        chk({req, " valid"}, {31'd0, addr_vld}, 32'd1);
        chk({req, " addr"}, addr_eff, exp);
        chk({req, " ext after"}, {24'd0, ext_byte}, {24'd0, m_ext});
        @(negedge clk);
        chk("R11 pulse width", {31'd0, addr_vld}, 32'd0);
    endtask

    initial begin
        int unsigned seed_init;
        logic [7:0] follow_ops [5];
        logic [7:0] fixed_ops [5];
        follow_ops = '{8'h03, 8'h02, 8'h0B, 8'h20, 8'hD8};
        fixed_ops  = '{8'h13, 8'h12, 8'h0C, 8'h21, 8'hDC};
        seed_init = $urandom(32'd2024);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 flag", {31'd0, wide_mode}, 32'd0);
        chk("R1 ext", {24'd0, ext_byte}, 32'd0);
        chk("R1 addr_vld", {31'd0, addr_vld}, 32'd0);
        chk("R1 rd_vld", {31'd0, ext_rd_vld}, 32'd0);

        do_addr("R5 narrow read", 8'h03, 32'h00123456, 1'b0);
        do_wrext(8'h05);
        do_rdext();
        do_addr("R5 ext composed", 8'h0B, 32'h00000010, 1'b0);
        do_mode(8'hB7);
        do_addr("R6 wide follow", 8'h03, 32'hAABBCCDD, 1'b0);
        do_mode(8'hE9);
        chk("R2 exit gives 01", {24'd0, ext_byte}, 32'h01);
        do_wrext(8'h07);
        do_mode(8'hE9);
        chk("R2 exit in narrow keeps", {24'd0, ext_byte}, 32'h07);
        do_addr("R7 fixed in narrow", 8'h13, 32'h02000000, 1'b0);
        do_addr("R5 after fixed", 8'h03, 32'h00ABCDEF, 1'b0);

        send_op(8'h9F);
        send_byte(8'h44); send_byte(8'h55); send_byte(8'h66); send_byte(8'h77);
        chk("R8 unknown no valid", {31'd0, addr_vld}, 32'd0);
        chk("R8 unknown ext", {24'd0, ext_byte}, {24'd0, m_ext});
        chk("R8 unknown flag", {31'd0, wide_mode}, {31'd0, m_mode});
        send_byte(8'h99);
        chk("R8 stray byte", {31'd0, addr_vld}, 32'd0);

        send_op(8'h03);
        send_byte(8'h11); send_byte(8'h22);
        send_op(8'h03, 1'b1);
        chk("R9 abandoned", {31'd0, addr_vld}, 32'd0);
        do_addr("R9 restart", 8'h03, 32'h00334455, 1'b0);

        do_mode(8'hB7);
        do_addr("R10 wide high", 8'h13, 32'h09000000, 1'b0);
        do_mode(8'hE9);
        do_wrext(8'h00);
        do_addr("R10 boot read", 8'h03, 32'h00000000, 1'b0);
        chk("R10 address zero", addr_eff, 32'h0);

        for (int k = 0; k < 400; k++) begin
            case ($urandom % 8)
                0: do_mode(8'hB7);
                1: do_mode(8'hE9);
                2: do_wrext(8'($urandom));
                3: do_rdext();
                4, 7: do_addr("R5/R6 random", follow_ops[$urandom % 5], $urandom, 1'b1);
                5: do_addr("R7 random", fixed_ops[$urandom % 5], $urandom, 1'b1);
                default: begin
                    send_op(8'h9F);
                    send_byte(8'($urandom));
                    chk("R8 random ignore", {31'd0, addr_vld}, 32'd0);
                    chk("R8 random ext", {24'd0, ext_byte}, {24'd0, m_ext});
                end
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule